// File: doc/BRIEF.md
# Cyclic Rotating Mask Stream Generator

This block produces a pseudorandom mask for one row of a circulant secret key, 32 bits per clock. The mask is a fixed ring of N = 32*FULL_WORDS+1 bits (4801 bits at the default FULL_WORDS = 150). The ring is drawn from a 32-bit linear recurrence, and a 32-bit seed fixes it. Each pass walks once around the ring as FULL_WORDS full words plus one single-bit word. Every new pass starts one bit earlier than the previous one, so the stream follows a key row that is rotated right by one bit per pass.

A combinational 32-step leap-forward function computes the next word of the recurrence. When a word runs past the end of the ring, its in-ring bits are joined to head bits of the ring. The recurrence window is then reloaded from a 64-bit seed/head pair. That pair rotates one bit per wrap, and after 32 wraps it returns to its loaded arrangement. Only a seed load and an advance strobe drive the block. Key storage and the logic that uses the mask are outside it.

Top module: `rot_mask_prg`

## Requirements
- R1: While rstN is low, and after reset until the first load, maskOut is zero and passEnd is low.
- R2: The sequence is defined as m[-32..-1] = seedIn bits 0..31 and m[k+32] = m[k] ^ m[k+1] ^ m[k+2] ^ m[k+22]. In the cycle after loadSeed, maskOut holds m[0..31], and bit i of any full output word carries sequence index base+i.
- R3: With advance and loadSeed both low, maskOut and passEnd keep their values.
- R4: A pass is FULL_WORDS full words followed by one final word. The final word carries the pass's last ring bit in bit 0 and zeros in bits 31:1, and passEnd is high only during that final word.
- R5: Pass p, counted from 0 at the last load, starts at ring index (N-p) mod N. Each full word starts 32 indices after the previous one, and indices past N-1 wrap to m[0] within the same word.
- R6: An advance during the final word does not move the ring position. The first word of the next pass starts at the bit the final word showed.
- R7: The output of pass p+N equals that of pass p for every p. The generator returns to its loaded state after N passes.
- R8: loadSeed takes priority over advance. It restarts the generator at pass 0, word 0, with the sequence of the new seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadSeed | input | 1 | Load seedIn and restart at pass 0 |
| seedIn | input | 32 | Recurrence window preceding ring bit 0 |
| advance | input | 1 | Step to the next output word |
| maskOut | output | 32 | Current mask word |
| passEnd | output | 1 | High during the single-bit final word of a pass |

## Verification
The bench runs a full-size generator and a three-word generator (a 97-bit ring) side by side. The small ring goes through every wrap offset from 0 to 31, including the case where a word ends exactly on the last ring bit. A wrong splice mask or a seed/head pair rotated by the wrong amount would corrupt the word after each wrap. The bench also holds advance high across final words: a design that stepped there would skip one bit and start every later pass out of phase. A load issued together with advance in the middle of a pass must restart cleanly. The small ring is run for many full periods, so any drift in the rotation or its swap-back would appear as a mismatch after N passes.

// File: rtl/rot_prg_pkg.sv
package rot_prg_pkg;

  localparam int WORD_W = 32;
  localparam int LEN_W  = 5;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic             load;
    logic             step;
    logic             splice;
    logic [LEN_W-1:0] spliceLen;
    logic             lastWord;
  } prg_ctrl_t;

  // Advance a 32-bit window of the recurrence by 32 positions.
  // Bit 0 is the oldest bit; taps follow x^32 + x^22 + x^2 + x + 1.
  function automatic logic [WORD_W-1:0] leapWord(input logic [WORD_W-1:0] win);
    logic [WORD_W-1:0] w;
    logic fb;
    w = win;
    for (int i = 0; i < WORD_W; i++) begin
      fb = w[0] ^ w[1] ^ w[2] ^ w[22];
      w  = {fb, w[WORD_W-1:1]};
    end
    return w;
  endfunction

  // Keep the low 'keep' bits of the tail, fill the rest with head bits.
  function automatic logic [WORD_W-1:0] spliceWord(input logic [WORD_W-1:0] tailWin,
                                                   input logic [WORD_W-1:0] head,
                                                   input logic [LEN_W-1:0] keep);
    logic [WORD_W-1:0] keepMask;
    keepMask = (WORD_W'(1) << keep) - WORD_W'(1);
    return (tailWin & keepMask) | (head << keep);
  endfunction

endpackage

// File: rtl/rot_prg_ctrl.sv
module rot_prg_ctrl
  import rot_prg_pkg::*;
#(
  parameter int FULL_WORDS = 150
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      loadSeed,
  input  logic      advance,
  output prg_ctrl_t ctrl
);

  localparam int SEQ_LEN = FULL_WORDS * WORD_W + 1;
  localparam int POS_W   = $clog2(SEQ_LEN + WORD_W);
  localparam int CNT_W   = $clog2(FULL_WORDS + 1);

  logic [CNT_W-1:0] wordCnt;
  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] posSum;
  logic             atLast;
  logic             stepNow;
  logic             wrapNext;

  assign atLast   = (wordCnt == CNT_W'(FULL_WORDS));
  assign stepNow  = advance && !loadSeed && !atLast;
  assign posSum   = pos + POS_W'(WORD_W);
  // next word reaches the ring end (partial tail) or lands exactly on index 0
  assign wrapNext = (posSum >= POS_W'(SEQ_LEN - (WORD_W - 1))) &&
                    (posSum <= POS_W'(SEQ_LEN));

  always_comb begin
    ctrl.load      = loadSeed;
    ctrl.step      = stepNow;
    ctrl.splice    = stepNow && wrapNext;
    ctrl.spliceLen = LEN_W'(POS_W'(SEQ_LEN) - posSum);
    ctrl.lastWord  = atLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordCnt <= '0;
      pos     <= '0;
    end else if (loadSeed) begin
      wordCnt <= '0;
      pos     <= '0;
    end else if (advance) begin
      if (atLast) begin
        wordCnt <= '0;
      end else begin
        wordCnt <= wordCnt + CNT_W'(1);
        pos     <= (posSum >= POS_W'(SEQ_LEN)) ? posSum - POS_W'(SEQ_LEN) : posSum;
      end
    end
  end

  p_pos_in_ring_r5: assert property (@(posedge clk) disable iff (!rstN)
    pos < POS_W'(SEQ_LEN));

  p_end_needs_advance_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(atLast) |-> $past(advance));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!advance && !loadSeed) |=> ($stable(wordCnt) && $stable(pos)));

  p_release_end_r6: assert property (@(posedge clk) disable iff (!rstN)
    (atLast && advance && !loadSeed) |=> (!atLast && $stable(pos)));

  p_load_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
    loadSeed |=> (wordCnt == '0 && pos == '0));

endmodule

// File: rtl/rot_prg_dpath.sv
module rot_prg_dpath
  import rot_prg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  prg_ctrl_t         ctrl,
  input  logic [WORD_W-1:0] seedIn,
  output logic [WORD_W-1:0] maskOut
);

  logic [WORD_W-1:0]   ivReg;      // seed half of the rotating pair
  logic [WORD_W-1:0]   intBitReg;  // head half of the rotating pair
  logic [WORD_W-1:0]   extBitReg;  // fixed copy of the ring head
  logic [WORD_W-1:0]   intState;   // window feeding the leap function
  logic [WORD_W-1:0]   extState;   // current output word
  logic [WORD_W-1:0]   leapIn;
  logic [WORD_W-1:0]   leapOut;
  logic [2*WORD_W-1:0] pairRot;

  assign leapIn  = ctrl.load ? seedIn : intState;
  assign leapOut = leapWord(leapIn);
  assign pairRot = {intBitReg[WORD_W-2:0], ivReg, intBitReg[WORD_W-1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ivReg     <= '0;
      intBitReg <= '0;
      extBitReg <= '0;
      intState  <= '0;
      extState  <= '0;
    end else if (ctrl.load) begin
      ivReg     <= seedIn;
      intBitReg <= leapOut;
      extBitReg <= leapOut;
      intState  <= leapOut;
      extState  <= leapOut;
    end else if (ctrl.step) begin
      if (ctrl.splice) begin
        extState <= spliceWord(leapOut, extBitReg, ctrl.spliceLen);
        if (ctrl.spliceLen == '0) begin
          // word lands on ring index 0: restart from head, pair swaps back
          intState               <= extBitReg;
          {intBitReg, ivReg}     <= {pairRot[WORD_W-1:0], pairRot[2*WORD_W-1:WORD_W]};
        end else begin
          intState               <= pairRot[2*WORD_W-1:WORD_W];
          {intBitReg, ivReg}     <= pairRot;
        end
      end else begin
        intState <= leapOut;
        extState <= leapOut;
      end
    end
  end

  assign maskOut = ctrl.lastWord ? {{(WORD_W-1){1'b0}}, extState[0]} : extState;

  p_pair_weight_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.splice && !ctrl.load) |=> ($countones({intBitReg, ivReg}) == $past($countones({intBitReg, ivReg}))));

  p_ext_frozen_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.step && !ctrl.load) |=> $stable(extState));

  p_head_kept_r5: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> $stable(extBitReg));

endmodule

// File: rtl/rot_mask_prg.sv
module rot_mask_prg
  import rot_prg_pkg::*;
#(
  parameter int FULL_WORDS = 150
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadSeed,
  input  logic [WORD_W-1:0] seedIn,
  input  logic              advance,
  output logic [WORD_W-1:0] maskOut,
  output logic              passEnd
);

  prg_ctrl_t ctrlBus;

  rot_prg_ctrl #(.FULL_WORDS(FULL_WORDS)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .loadSeed (loadSeed),
    .advance  (advance),
    .ctrl     (ctrlBus)
  );

  rot_prg_dpath i_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrlBus),
    .seedIn  (seedIn),
    .maskOut (maskOut)
  );

  assign passEnd = ctrlBus.lastWord;

  p_end_low_bits_r4: assert property (@(posedge clk) disable iff (!rstN)
    passEnd |-> (maskOut[WORD_W-1:1] == '0));

endmodule

// File: tb/test_rot_mask_prg.sv
`timescale 1ns/1ps
module test_rot_mask_prg;

  localparam int BIG_WORDS   = 150;
  localparam int SMALL_WORDS = 3;
  localparam int BIG_LEN     = BIG_WORDS * 32 + 1;
  localparam int SMALL_LEN   = SMALL_WORDS * 32 + 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadSeed = 1'b0;
  logic        advance = 1'b0;
  logic [31:0] seedIn = '0;
  logic [31:0] maskBig, maskSmall;
  logic        endBig, endSmall;

  always #2.5 clk = ~clk;

  rot_mask_prg i_rot_mask_prg (
    .clk(clk), .rstN(rstN), .loadSeed(loadSeed), .seedIn(seedIn),
    .advance(advance), .maskOut(maskBig), .passEnd(endBig)
  );

  rot_mask_prg #(.FULL_WORDS(SMALL_WORDS)) i_rot_mask_prg_small (
    .clk(clk), .rstN(rstN), .loadSeed(loadSeed), .seedIn(seedIn),
    .advance(advance), .maskOut(maskSmall), .passEnd(endSmall)
  );

  bit seqBits [0:BIG_LEN-1];
  int checks = 0;
  int fails  = 0;
  int passBig = 0, wordBig = 0, passSmall = 0, wordSmall = 0;
  bit done = 1'b0;
  logic [31:0] curSeed = '0;
  int unsigned dummy;

  task automatic buildSeq(input logic [31:0] s);
    bit ext [0:BIG_LEN+31];
    for (int i = 0; i < 32; i++) ext[i] = s[i];
    for (int i = 32; i < BIG_LEN + 32; i++)
      ext[i] = ext[i-32] ^ ext[i-31] ^ ext[i-30] ^ ext[i-10];
    for (int i = 0; i < BIG_LEN; i++) seqBits[i] = ext[i+32];
  endtask

  function automatic logic [31:0] expWord(int seqLen, int words, int pass, int word);
    int start, base;
    logic [31:0] w;
    w = '0;
    start = (seqLen - (pass % seqLen)) % seqLen;
    base  = (start + 32 * word) % seqLen;
    if (word == words) w[0] = seqBits[base];
    else for (int i = 0; i < 32; i++) w[i] = seqBits[(base + i) % seqLen];
    return w;
  endfunction

  function automatic string pickTag(string ctx, int seqLen, int words, int pass, int word);
    if (ctx != "") return ctx;
    if (word == words) return "R4";
    if (pass >= seqLen) return "R7";
    if (pass > 0 && word == 0) return "R6";
    if (pass > 0) return "R5";
    return "R2";
  endfunction

  task automatic checkVal(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(string ctx);
    string tb, ts;
    tb = pickTag(ctx, BIG_LEN, BIG_WORDS, passBig, wordBig);
    ts = pickTag(ctx, SMALL_LEN, SMALL_WORDS, passSmall, wordSmall);
    checkVal(tb, "big mask", maskBig, expWord(BIG_LEN, BIG_WORDS, passBig, wordBig));
    checkVal(tb, "big passEnd", {31'b0, endBig}, {31'b0, wordBig == BIG_WORDS});
    checkVal(ts, "small mask", maskSmall, expWord(SMALL_LEN, SMALL_WORDS, passSmall, wordSmall));
    checkVal(ts, "small passEnd", {31'b0, endSmall}, {31'b0, wordSmall == SMALL_WORDS});
  endtask

  task automatic stepCycle(bit adv, bit ld, logic [31:0] sd, string ldTag);
    string ctx;
    advance  = adv;
    loadSeed = ld;
    seedIn   = sd;
    @(posedge clk);
    @(negedge clk);
    ctx = "";
    if (ld) begin
      buildSeq(sd);
      curSeed = sd;
      passBig = 0; wordBig = 0; passSmall = 0; wordSmall = 0;
      ctx = ldTag;
    end else if (adv) begin
      if (wordBig == BIG_WORDS) begin wordBig = 0; passBig++; end
      else wordBig++;
      if (wordSmall == SMALL_WORDS) begin wordSmall = 0; passSmall++; end
      else wordSmall++;
    end else begin
      ctx = "R3";
    end
    checkAll(ctx);
  endtask

  initial begin
    dummy = $urandom(32'h5eed_2024);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    checkVal("R1", "big mask in reset", maskBig, 32'h0);
    checkVal("R1", "big passEnd in reset", {31'b0, endBig}, 32'h0);
    checkVal("R1", "small mask in reset", maskSmall, 32'h0);
    checkVal("R1", "small passEnd in reset", {31'b0, endSmall}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R1", "big mask after reset", maskBig, 32'h0);
    checkVal("R1", "small passEnd after reset", {31'b0, endSmall}, 32'h0);

    // R2: first load, then idle cycles for R3
    stepCycle(1'b0, 1'b1, 32'h9e37_79b9, "R2");
    for (int i = 0; i < 3; i++) stepCycle(1'b0, 1'b0, curSeed, "");

    // R4/R6: walk straight through two small passes
    for (int i = 0; i < 10; i++) stepCycle(1'b1, 1'b0, curSeed, "");

    // random advance pattern
    for (int i = 0; i < 3000; i++)
      stepCycle(($urandom % 8) != 0, 1'b0, curSeed, "");

    // R8: reload in mid-pass while advance is high
    stepCycle(1'b1, 1'b1, 32'h1234_abcd, "R8");

    // long run: big ring goes through every wrap offset, small ring many periods (R7)
    for (int i = 0; i < 6000; i++)
      stepCycle(($urandom % 16) != 0, 1'b0, curSeed, "");

    // R8: reload with a zero-heavy seed
    stepCycle(1'b0, 1'b1, 32'h0000_0001, "R8");
    for (int i = 0; i < 400; i++)
      stepCycle(($urandom % 4) != 0, 1'b0, curSeed, "");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule